// File: doc/BRIEF.md
# USB Device-Mode State Controller

This block is the top-level control state machine of a full/low-speed USB device-mode controller. It follows the device role through four states: Reset, Idle, Active, and a short Cleanup run. It drives the single pull-up resistor that announces the device's speed to the host. It owns the clock-freeze flag and the software detach flag. It also holds the enable mask and the bank-allocation mask for the control endpoint (bit 0) and six configurable endpoints (bits 6:1).

Software writes the detach flag, clears the clock freeze and loads the endpoint masks through simple write strobes. When the host drives a bus reset while the device is attached, the block runs a fixed four-step cleanup and then raises a sticky end-of-reset flag. Line signalling, packet handling and the transceiver are handled by other blocks.

Top module: `usbd_dev_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released with macro_en low, dev_state is 0 (Reset), frz_clk is 1, ep_en and bank_alloc are 0, ctl_tgl_clr and eorst_flag are 0, and both pull-ups are 0.
- R2: In Reset, the block moves to Idle (dev_state 1) at the next clock edge only when macro_en is 1 and id_dev is 1. Otherwise it stays in Reset.
- R3: From any state, macro_en = 0 or id_dev = 0 at a clock edge returns the block to Reset with the R1 values: detach set, frz_clk set, masks and flags cleared. Any cleanup in progress is abandoned. Software writes made in that cycle have no effect.
- R4: dp_pu equals NOT low_speed and dm_pu equals low_speed, but only while the state is not Reset, the internal detach flag is 0 and vbus_ok is 1. Otherwise both are 0. At most one pull-up is ever driven.
- R5: From Idle, the block enters Active (dev_state 2) at the edge after the detach flag is 0 and vbus_ok is 1. From Active, it returns to Idle when either condition is lost.
- R6: bus_rst_det high at an edge in Active starts the cleanup (dev_state 3) at that edge. In Idle, bus_rst_det has no effect.
- R7: At the first edge after cleanup starts, frz_clk goes to 1 and the detach flag goes to 1, so both pull-ups drop to 0.
- R8: At the second cleanup edge, ep_en becomes 7'b0000001 (only the control endpoint enabled) and bank_alloc becomes 0.
- R9: At the third cleanup edge, ctl_tgl_clr goes high for exactly one cycle.
- R10: At the fourth cleanup edge, eorst_flag is set and the state returns to Idle.
- R11: eorst_flag stays set until an eorst_clr strobe clears it. If the set and the clear come in the same cycle, the flag ends up set.
- R12: In Idle or Active, detach_wr loads detach_val into the detach flag, frz_clr clears frz_clk, and cfg_wr loads cfg_ep_en and cfg_bank. During cleanup, all three writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low hardware reset |
| macro_en | input | 1 | Macro enable; 0 forces Reset |
| id_dev | input | 1 | Role pin; 1 = device, 0 = host |
| vbus_ok | input | 1 | Bus power present |
| low_speed | input | 1 | 1 = low speed (D- pull-up), 0 = full speed (D+ pull-up) |
| detach_wr | input | 1 | Strobe to write the detach flag |
| detach_val | input | 1 | Value written to the detach flag |
| frz_clr | input | 1 | Strobe to clear the clock-freeze flag |
| cfg_wr | input | 1 | Strobe to load the endpoint masks |
| cfg_ep_en | input | 7 | Endpoint enable mask to load |
| cfg_bank | input | 7 | Bank-allocation mask to load |
| bus_rst_det | input | 1 | Host bus reset detected on the line |
| eorst_clr | input | 1 | Write-one-to-clear strobe for eorst_flag |
| dp_pu | output | 1 | D+ pull-up enable |
| dm_pu | output | 1 | D- pull-up enable |
| frz_clk | output | 1 | Clock-freeze flag |
| ep_en | output | 7 | Endpoint enable mask, bit 0 = control |
| bank_alloc | output | 7 | Endpoint bank-allocation mask |
| ctl_tgl_clr | output | 1 | One-cycle clear of the control endpoint data toggle |
| eorst_flag | output | 1 | Sticky end-of-reset interrupt flag |
| dev_state | output | 2 | 0 Reset, 1 Idle, 2 Active, 3 Cleanup |

## Verification
The pull-up decode is driven through all eight combinations of detach, bus power and speed. This separates the speed choice from the two attach conditions. The cleanup run is sampled after each of its edges, so an action that lands one step early or late, or is missing, shows up at its own step. Further runs cover a clear strobe held across the final step (set must win), a bus reset in Idle (must be ignored), and an enable drop in the middle of the cleanup (must abort cleanly to Reset).

// File: rtl/usbd_pkg.sv
package usbd_pkg;
    typedef enum logic [1:0] {
        DS_RESET  = 2'd0,
        DS_IDLE   = 2'd1,
        DS_ACTIVE = 2'd2,
        DS_CLEAN  = 2'd3
    } dev_st_e;
endpackage

// File: rtl/usbd_pullup_dec.sv
module usbd_pullup_dec (
    input  logic connected,
    input  logic detach,
    input  logic vbus_ok,
    input  logic low_speed,
    output logic dp_pu,
    output logic dm_pu
);
    logic drive;

    always_comb begin
        drive = connected && !detach && vbus_ok;
        dp_pu = drive && !low_speed;
        dm_pu = drive && low_speed;
    end

    always_comb begin
        AST_ONE_PULLUP: assert (!(dp_pu && dm_pu)); // R4
    end
endmodule

// File: rtl/usbd_clean_seq.sv
module usbd_clean_seq #(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic act_detach,
    output logic act_eps,
    output logic act_tgl,
    output logic act_eor,
    output logic busy
);
    localparam int SW = $clog2(STEPS + 1);
    localparam logic [SW-1:0] S_DET = SW'(1);
    localparam logic [SW-1:0] S_EPS = SW'(2);
    localparam logic [SW-1:0] S_TGL = SW'(3);
    localparam logic [SW-1:0] S_EOR = SW'(STEPS);

    logic [SW-1:0] step_d, step_q;

    always_comb begin
        step_d = step_q;
        if (abort)
            step_d = '0;
        else if (step_q == '0)
            step_d = start ? S_DET : '0;
        else if (step_q == S_EOR)
            step_d = '0;
        else
            step_d = step_q + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assign act_detach = (step_q == S_DET);
    assign act_eps    = (step_q == S_EPS);
    assign act_tgl    = (step_q == S_TGL);
    assign act_eor    = (step_q == S_EOR);
    assign busy       = (step_q != '0);

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !act_eor) |=> busy); // R7
    AST_SEQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_detach, act_eps, act_tgl, act_eor})); // R10
endmodule

// File: rtl/usbd_dev_ctrl.sv
module usbd_dev_ctrl #(
    parameter int NUM_CFG_EP = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  macro_en,
    input  logic                  id_dev,
    input  logic                  vbus_ok,
    input  logic                  low_speed,
    input  logic                  detach_wr,
    input  logic                  detach_val,
    input  logic                  frz_clr,
    input  logic                  cfg_wr,
    input  logic [NUM_CFG_EP:0]   cfg_ep_en,
    input  logic [NUM_CFG_EP:0]   cfg_bank,
    input  logic                  bus_rst_det,
    input  logic                  eorst_clr,
    output logic                  dp_pu,
    output logic                  dm_pu,
    output logic                  frz_clk,
    output logic [NUM_CFG_EP:0]   ep_en,
    output logic [NUM_CFG_EP:0]   bank_alloc,
    output logic                  ctl_tgl_clr,
    output logic                  eorst_flag,
    output logic [1:0]            dev_state
);
    import usbd_pkg::*;

    localparam int NUM_EP = NUM_CFG_EP + 1;
    localparam logic [NUM_EP-1:0] CTL_ONLY = NUM_EP'(1);

    typedef struct packed {
        dev_st_e           st;
        logic              detach;
        logic              frz;
        logic [NUM_EP-1:0] ep_en;
        logic [NUM_EP-1:0] bank;
        logic              tgl;
        logic              eorst;
    } regs_t;

    localparam regs_t RST_VAL = '{st: DS_RESET, detach: 1'b1, frz: 1'b1,
                                  ep_en: '0, bank: '0, tgl: 1'b0, eorst: 1'b0};

    regs_t r_d, r_q;
    logic  role_ok, attached, seq_start, seq_abort;
    logic  act_detach, act_eps, act_tgl, act_eor, seq_busy;

    usbd_clean_seq #(.STEPS(4)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .abort(seq_abort),
        .act_detach(act_detach), .act_eps(act_eps), .act_tgl(act_tgl),
        .act_eor(act_eor), .busy(seq_busy)
    );

    usbd_pullup_dec u_pu (
        .connected(r_q.st != DS_RESET), .detach(r_q.detach),
        .vbus_ok(vbus_ok), .low_speed(low_speed),
        .dp_pu(dp_pu), .dm_pu(dm_pu)
    );

    always_comb begin
        r_d       = r_q;
        r_d.tgl   = 1'b0;
        seq_start = 1'b0;
        seq_abort = 1'b0;
        role_ok   = macro_en && id_dev;
        attached  = !r_q.detach && vbus_ok;
        if (!role_ok) begin
            r_d       = RST_VAL;
            seq_abort = 1'b1;
        end else begin
            unique case (r_q.st)
                DS_RESET: r_d.st = DS_IDLE;
                DS_IDLE, DS_ACTIVE: begin
                    if (detach_wr) r_d.detach = detach_val;
                    if (frz_clr)   r_d.frz    = 1'b0;
                    if (cfg_wr) begin
                        r_d.ep_en = cfg_ep_en;
                        r_d.bank  = cfg_bank;
                    end
                    if (eorst_clr) r_d.eorst = 1'b0;
                    if (r_q.st == DS_ACTIVE && bus_rst_det) begin
                        r_d.st    = DS_CLEAN;
                        seq_start = 1'b1;
                    end else begin
                        r_d.st = attached ? DS_ACTIVE : DS_IDLE;
                    end
                end
                DS_CLEAN: begin
                    if (eorst_clr) r_d.eorst = 1'b0;
                    if (act_detach) begin
                        r_d.frz    = 1'b1;
                        r_d.detach = 1'b1;
                    end
                    if (act_eps) begin
                        r_d.ep_en = CTL_ONLY;
                        r_d.bank  = '0;
                    end
                    if (act_tgl) r_d.tgl = 1'b1;
                    if (act_eor) begin
                        r_d.eorst = 1'b1;
                        r_d.st    = DS_IDLE;
                    end
                end
                default: r_d = RST_VAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign frz_clk     = r_q.frz;
    assign ep_en       = r_q.ep_en;
    assign bank_alloc  = r_q.bank;
    assign ctl_tgl_clr = r_q.tgl;
    assign eorst_flag  = r_q.eorst;
    assign dev_state   = r_q.st;

    AST_ROLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!macro_en || !id_dev) |=> (dev_state == 2'd0 && !seq_busy)); // R3
    AST_RESET_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == 2'd0) |-> (!dp_pu && !dm_pu)); // R4
    AST_CLEAN_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_detach && role_ok) |=> (frz_clk && !dp_pu && !dm_pu)); // R7
    AST_CLEAN_EPS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_eps && role_ok) |=> (ep_en == CTL_ONLY && bank_alloc == '0)); // R8
    AST_TGL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tgl_clr |=> !ctl_tgl_clr); // R9
    AST_EOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eorst_flag && !eorst_clr && role_ok) |=> eorst_flag); // R11
    AST_CLEAN_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(dev_state == 2'd2)); // R6
endmodule

// File: tb/tb_usbd_dev_ctrl.sv
module tb_usbd_dev_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic macro_en = 0, id_dev = 0, vbus_ok = 0, low_speed = 0;
    logic detach_wr = 0, detach_val = 0, frz_clr = 0, cfg_wr = 0;
    logic [6:0] cfg_ep_en = '0, cfg_bank = '0;
    logic bus_rst_det = 0, eorst_clr = 0;
    logic dp_pu, dm_pu, frz_clk, ctl_tgl_clr, eorst_flag;
    logic [6:0] ep_en, bank_alloc;
    logic [1:0] dev_state;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbd_dev_ctrl dut (
        .clk(clk), .rst_n(rst_n), .macro_en(macro_en), .id_dev(id_dev),
        .vbus_ok(vbus_ok), .low_speed(low_speed), .detach_wr(detach_wr),
        .detach_val(detach_val), .frz_clr(frz_clr), .cfg_wr(cfg_wr),
        .cfg_ep_en(cfg_ep_en), .cfg_bank(cfg_bank), .bus_rst_det(bus_rst_det),
        .eorst_clr(eorst_clr), .dp_pu(dp_pu), .dm_pu(dm_pu), .frz_clk(frz_clk),
        .ep_en(ep_en), .bank_alloc(bank_alloc), .ctl_tgl_clr(ctl_tgl_clr),
        .eorst_flag(eorst_flag), .dev_state(dev_state)
    );

    // {detach, vbus_ok, low_speed, expected dp_pu, expected dm_pu}
    localparam logic [4:0] PU_VEC [8] = '{
        5'b000_00, 5'b001_00, 5'b010_10, 5'b011_01,
        5'b100_00, 5'b101_00, 5'b110_00, 5'b111_00
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_detach(input logic v);
        detach_wr = 1; detach_val = v; step(); detach_wr = 0;
    endtask

    task automatic go_active();
        vbus_ok = 1; low_speed = 0;
        wr_detach(1'b0);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        chk(dev_state == 0 && frz_clk && ep_en == 0 && bank_alloc == 0 &&
            !eorst_flag && !ctl_tgl_clr && !dp_pu && !dm_pu, "R1 reset", dev_state, 0);
        rst_n = 1;
        id_dev = 1; vbus_ok = 1;
        wr_detach(1'b0);   // R3: write ignored while disabled
        step();
        chk(dev_state == 0 && frz_clk, "R1 hold disabled", dev_state, 0);
        macro_en = 1; id_dev = 0;
        step(); step();
        chk(dev_state == 0, "R2 host role stays Reset", dev_state, 0);
        id_dev = 1;
        step();
        chk(dev_state == 1, "R2 enter Idle", dev_state, 1);
        chk(!dp_pu && !dm_pu, "R3 detach write in Reset ignored", dp_pu, 0);

        // R4 / R5 pull-up vector table
        for (int i = 0; i < 8; i++) begin
            vbus_ok = PU_VEC[i][3]; low_speed = PU_VEC[i][2];
            wr_detach(PU_VEC[i][4]);
            chk(dp_pu == PU_VEC[i][1] && dm_pu == PU_VEC[i][0], "R4 pull-up decode",
                {dp_pu, dm_pu}, PU_VEC[i][1:0]);
        end

        // R12 software writes
        frz_clr = 1; cfg_wr = 1; cfg_ep_en = 7'h7E; cfg_bank = 7'h55;
        step();
        frz_clr = 0; cfg_wr = 0;
        chk(!frz_clk && ep_en == 7'h7E && bank_alloc == 7'h55, "R12 writes in Idle", ep_en, 7'h7E);

        // R6 bus reset ignored in Idle
        bus_rst_det = 1; step(); bus_rst_det = 0; step(); step();
        chk(dev_state == 1 && ep_en == 7'h7E && frz_clk == 0, "R6 ignored in Idle", dev_state, 1);

        go_active();
        chk(dev_state == 2 && dp_pu, "R5 enter Active", dev_state, 2);
        vbus_ok = 0; step();
        chk(dev_state == 1, "R5 back to Idle on VBus loss", dev_state, 1);
        vbus_ok = 1; step();
        chk(dev_state == 2, "R5 Active again", dev_state, 2);

        // cleanup walk
        bus_rst_det = 1; step(); bus_rst_det = 0;
        chk(dev_state == 3 && !frz_clk && dp_pu, "R6 cleanup start", dev_state, 3);
        cfg_wr = 1; cfg_ep_en = 7'h7F; cfg_bank = 7'h7F;
        step();
        chk(frz_clk && !dp_pu && !dm_pu && ep_en == 7'h7E, "R7 freeze and detach", frz_clk, 1);
        cfg_wr = 0; detach_wr = 1; detach_val = 0;
        step();
        detach_wr = 0;
        chk(ep_en == 7'h01 && bank_alloc == 0 && !ctl_tgl_clr, "R8 endpoints dropped", ep_en, 1);
        step();
        chk(ctl_tgl_clr && !eorst_flag, "R9 toggle clear", ctl_tgl_clr, 1);
        step();
        chk(!ctl_tgl_clr && eorst_flag && dev_state == 1, "R10 end of reset", eorst_flag, 1);
        chk(!dp_pu && ep_en == 7'h01, "R12 writes in cleanup ignored", dp_pu, 0);
        step(); step(); step();
        chk(eorst_flag, "R11 flag sticky", eorst_flag, 1);
        eorst_clr = 1; step(); eorst_clr = 0;
        chk(!eorst_flag, "R11 clear", eorst_flag, 0);

        // R11 set wins over clear
        go_active();
        eorst_clr = 1;
        bus_rst_det = 1; step(); bus_rst_det = 0;
        step(); step(); step(); step();
        chk(eorst_flag && dev_state == 1, "R11 set wins", eorst_flag, 1);
        eorst_clr = 0; step();
        chk(eorst_flag, "R11 held after set", eorst_flag, 1);

        // R3 abort in the middle of cleanup
        go_active();
        bus_rst_det = 1; step(); bus_rst_det = 0;
        step();
        macro_en = 0; step();
        chk(dev_state == 0 && frz_clk && ep_en == 0 && bank_alloc == 0 && !eorst_flag &&
            !dp_pu, "R3 abort to Reset", dev_state, 0);
        macro_en = 1; step(); step(); step(); step();
        chk(dev_state == 1 && !eorst_flag && ep_en == 0 && !ctl_tgl_clr, "R3 no resumed cleanup",
            eorst_flag, 0);

        // R3 host role from Active
        go_active();
        id_dev = 0; step();
        chk(dev_state == 0 && !dp_pu && !dm_pu, "R3 host role from Active", dev_state, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule